// File: doc/BRIEF.md
# Four-Lane Fixed-Point Dot Product and Matrix Transform Unit

The unit takes 4-element vectors packed into 128-bit words. Each word holds four signed Q16.16 lanes, and lane j sits at bits 32j+31 down to 32j. It performs two operations.

- **Dot operation.** It forms the inner product of two vectors. It can accept a new pair on every clock.
- **Transform operation.** It multiplies a stored 4x4 coefficient matrix by one vector. It does this by sending the four matrix rows through the same dot-product datapath on four consecutive cycles.

The matrix is written one row per cycle through a separate load port that is always accepted. Results leave on a single valid-only output port, in the order the operations were issued.

The issue port is valid/ready. An operation is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` does not depend on `in_valid` and is high whenever no transform is still occupying the datapath. A requester that sees `in_ready` low must hold its operation until it is accepted. The result port has no back-pressure: a consumer must take every beat on which `out_valid` is high.

Top module: `vdt_unit`

## Requirements
- R1: A dot operation returns, in bits 31:0, the sum over lanes j of (a_j * b_j) arithmetic-shifted right by 16 and truncated to 32 bits, with the total wrapped to 32 bits; bits 127:32 of that result are zero.
- R2: While no transform is in progress, `in_ready` is high, so dot operations are accepted on every consecutive cycle.
- R3: A dot result appears with `out_valid` high exactly three cycles after the cycle in which it was accepted.
- R4: A transform returns element i = sum over j of M[i][j] * v_j, using the same fixed-point product and wrap rules as R1, with element i placed at bits 32i+31 down to 32i.
- R5: After a transform is accepted, `in_ready` is low for exactly three cycles and then high again, so one transform can start every four cycles.
- R6: A transform result appears as a single `out_valid` beat exactly six cycles after its acceptance cycle.
- R7: When `mat_we` is high, row `mat_row` of the matrix takes `mat_data`, with column j at bits 32j+31 down to 32j. A transform uses the matrix exactly as it stood before the clock edge on which it was accepted. A row write in that same cycle, or during the next three cycles, does not change that transform's result.
- R8: Results leave in the order their operations were accepted, with one output beat per accepted operation.
- R9: During and after reset, `out_valid` is low, `in_ready` is high, and all matrix rows are zero, so a transform issued before any load returns zero.
- R10: `in_op` = 0 selects the dot operation and `in_op` = 1 selects the transform. A transform takes its vector from `in_a` and ignores `in_b`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered on the issue port |
| in_ready | output | 1 | Issue port can accept an operation |
| in_op | input | 1 | 0 = dot, 1 = transform |
| in_a | input | 128 | First vector (transform input vector) |
| in_b | input | 128 | Second vector for dot; ignored by transform |
| mat_we | input | 1 | Matrix row write enable |
| mat_row | input | 2 | Index of the matrix row to write |
| mat_data | input | 128 | Row contents, column j in lane j |
| out_valid | output | 1 | Result beat present |
| out_data | output | 128 | Result word |

## Verification
The assertions check these properties on every cycle:
- the three-cycle and six-cycle result latencies;
- the three-cycle ready drop after every transform;
- that transform rows reach the output stage in ascending order on back-to-back cycles.

The bench scenarios are needed for the rest:
- the arithmetic itself, including truncation of negative products and 32-bit wrap;
- isolation of an in-flight transform from matrix writes made in its issue cycle and while it runs;
- the zeroed matrix after reset;
- result ordering when dot and transform operations are interleaved.

// File: rtl/vdt_pkg.sv
package vdt_pkg;
  localparam int LANES = 4;
  localparam int ROW_W = $clog2(LANES);

  typedef enum logic {
    OP_DOT   = 1'b0,
    OP_XFORM = 1'b1
  } op_e;

  // Travels beside the data through the dot datapath
  typedef struct packed {
    logic             valid;
    logic             is_row;
    logic [ROW_W-1:0] row;
  } tag_t;
endpackage

// File: rtl/vdt_seq.sv
module vdt_seq
  import vdt_pkg::*;
#(
  parameter int LANE_W = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               in_valid,
  input  logic                               in_op,
  input  logic [LANES*LANE_W-1:0]            in_a,
  input  logic [LANES*LANE_W-1:0]            in_b,
  input  logic [LANES-1:0][LANES*LANE_W-1:0] mat,
  output logic                               in_ready,
  output logic [LANES*LANE_W-1:0]            x_vec,
  output logic [LANES*LANE_W-1:0]            y_vec,
  output tag_t                               tag
);
  localparam int VEC_W = LANES * LANE_W;
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(LANES - 1);

  logic                          busy;
  logic [ROW_W-1:0]              row_q;
  logic [VEC_W-1:0]              vec_q;
  logic [LANES-1:0][VEC_W-1:0]   snap_q;
  logic                          accept;

  assign in_ready = ~busy;
  assign accept   = in_valid & ~busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      row_q <= '0;
    end else if (accept && in_op == OP_XFORM) begin
      busy  <= 1'b1;
      row_q <= ROW_W'(1);
    end else if (busy) begin
      row_q <= row_q + 1'b1;
      if (row_q == LAST_ROW) busy <= 1'b0;
    end
  end

  // Snapshot of the matrix as it was before the issuing edge
  always_ff @(posedge clk) begin
    if (accept && in_op == OP_XFORM) begin
      vec_q  <= in_a;
      snap_q <= mat;
    end
  end

  always_comb begin
    x_vec = '0;
    y_vec = '0;
    tag   = '0;
    if (busy) begin
      x_vec = snap_q[row_q];
      y_vec = vec_q;
      tag   = '{valid: 1'b1, is_row: 1'b1, row: row_q};
    end else if (accept) begin
      if (in_op == OP_XFORM) begin
        x_vec = mat[0];
        y_vec = in_a;
        tag   = '{valid: 1'b1, is_row: 1'b1, row: '0};
      end else begin
        x_vec = in_a;
        y_vec = in_b;
        tag   = '{valid: 1'b1, is_row: 1'b0, row: '0};
      end
    end
  end

  // R5: three cycles of back-pressure, then ready again
  a_r5_ready_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == OP_XFORM)
      |=> !in_ready ##1 !in_ready ##1 !in_ready ##1 in_ready);
endmodule

// File: rtl/vdt_dot4.sv
module vdt_dot4
  import vdt_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int FRAC_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES*LANE_W-1:0] x_vec,
  input  logic [LANES*LANE_W-1:0] y_vec,
  input  tag_t                    tag_in,
  output logic [LANE_W-1:0]       sum_q,
  output tag_t                    tag_out
);
  logic [LANES-1:0][LANE_W-1:0] prod_d, prod_q;
  tag_t                         tag1;
  logic [LANE_W-1:0]            acc;

  function automatic logic [LANE_W-1:0] fx_mul(input logic [LANE_W-1:0] a,
                                               input logic [LANE_W-1:0] b);
    logic signed [2*LANE_W-1:0] p;
    p = $signed(a) * $signed(b);
    return p[FRAC_W +: LANE_W];
  endfunction

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign prod_d[l] = fx_mul(x_vec[l*LANE_W +: LANE_W], y_vec[l*LANE_W +: LANE_W]);
  end

  always_comb begin
    acc = '0;
    for (int l = 0; l < LANES; l++) acc = acc + prod_q[l];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tag1    <= '0;
      tag_out <= '0;
    end else begin
      tag1    <= tag_in;
      tag_out <= tag1;
    end
  end

  always_ff @(posedge clk) begin
    prod_q <= prod_d;
    sum_q  <= acc;
  end

  // R3: a sum leaves this stage only two cycles after an operand entered
  a_r3_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
    tag_in.valid |=> ##1 tag_out.valid);
endmodule

// File: rtl/vdt_pack.sv
module vdt_pack
  import vdt_pkg::*;
#(
  parameter int LANE_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANE_W-1:0]       sum,
  input  tag_t                    tag,
  output logic                    out_valid,
  output logic [LANES*LANE_W-1:0] out_data
);
  localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(LANES - 1);

  logic [LANES-2:0][LANE_W-1:0] col_q;
  logic [LANES*LANE_W-1:0]      full_row;

  always_comb begin
    full_row = '0;
    for (int i = 0; i < LANES - 1; i++) full_row[i*LANE_W +: LANE_W] = col_q[i];
    full_row[(LANES-1)*LANE_W +: LANE_W] = sum;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= tag.valid && (!tag.is_row || tag.row == LAST_ROW);
  end

  always_ff @(posedge clk) begin
    if (tag.valid) begin
      if (!tag.is_row)            out_data <= {{(LANES-1)*LANE_W{1'b0}}, sum};
      else if (tag.row == LAST_ROW) out_data <= full_row;
      else                        col_q[tag.row[ROW_W-1:0]] <= sum;
    end
  end

  // R8: transform rows arrive back-to-back in ascending order
  a_r8_row_order: assert property (@(posedge clk) disable iff (!rst_n)
    (tag.valid && tag.is_row && tag.row != '0)
      |-> ($past(tag.valid) && $past(tag.is_row) && ($past(tag.row) == tag.row - 1'b1)));
endmodule

// File: rtl/vdt_unit.sv
module vdt_unit
  import vdt_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int FRAC_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_op,
  input  logic [LANES*LANE_W-1:0] in_a,
  input  logic [LANES*LANE_W-1:0] in_b,
  input  logic                    mat_we,
  input  logic [ROW_W-1:0]        mat_row,
  input  logic [LANES*LANE_W-1:0] mat_data,
  output logic                    out_valid,
  output logic [LANES*LANE_W-1:0] out_data
);
  localparam int VEC_W = LANES * LANE_W;

  logic [LANES-1:0][VEC_W-1:0] mat_q;
  logic [VEC_W-1:0]            x_vec, y_vec;
  tag_t                        tag0, tag2;
  logic [LANE_W-1:0]           sum;

  always_ff @(posedge clk) begin
    if (!rst_n)      mat_q <= '0;
    else if (mat_we) mat_q[mat_row] <= mat_data;
  end

  vdt_seq #(.LANE_W(LANE_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_a(in_a), .in_b(in_b), .mat(mat_q), .in_ready(in_ready),
    .x_vec(x_vec), .y_vec(y_vec), .tag(tag0)
  );

  vdt_dot4 #(.LANE_W(LANE_W), .FRAC_W(FRAC_W)) u_dot (
    .clk(clk), .rst_n(rst_n), .x_vec(x_vec), .y_vec(y_vec),
    .tag_in(tag0), .sum_q(sum), .tag_out(tag2)
  );

  vdt_pack #(.LANE_W(LANE_W)) u_pack (
    .clk(clk), .rst_n(rst_n), .sum(sum), .tag(tag2),
    .out_valid(out_valid), .out_data(out_data)
  );

  // R3: dot result three cycles after acceptance
  a_r3_dot_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == OP_DOT) |-> ##3 out_valid);

  // R6: transform result six cycles after acceptance
  a_r6_xform_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == OP_XFORM) |-> ##6 out_valid);

  // R6: a transform occupies exactly one output beat
  a_r6_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_op == OP_XFORM) |-> ##5 !out_valid);
endmodule

// File: tb/tb_vdt_unit.sv
module tb_vdt_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;

  localparam logic [127:0] TA [NV] = '{
    128'h00040000_00030000_00020000_00010000,
    128'hFFFF0000_00020000_FFFE0000_00008000,
    128'h00008000_00008000_00008000_00008000,
    128'h7FFF0000_7FFF0000_00000000_00000000,
    128'h00000000_00000000_00000000_FFFFFFFF,
    128'h00000000_00000000_00000000_00000000
  };
  localparam logic [127:0] TB [NV] = '{
    128'h00010000_00010000_00010000_00010000,
    128'h00030000_FFFF0000_00010000_00020000,
    128'h00008000_00008000_00008000_00008000,
    128'h00020000_00020000_00000000_00000000,
    128'h00000000_00000000_00000000_00000001,
    128'h12345678_9ABCDEF0_0BADF00D_DEADBEEF
  };

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_op = 0, mat_we = 0;
  logic [127:0] in_a = '0, in_b = '0, mat_data = '0;
  logic [1:0] mat_row = '0;
  logic in_ready, out_valid;
  logic [127:0] out_data;

  int checks = 0, errors = 0, cyc = 0;
  logic [127:0] mrow [4];

  typedef struct { logic [127:0] d; int due; string req; } exp_t;
  exp_t q[$];

  vdt_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .mat_we(mat_we),
    .mat_row(mat_row), .mat_data(mat_data), .out_valid(out_valid),
    .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] bdot(logic [127:0] a, logic [127:0] b);
    logic [31:0] s = '0;
    for (int j = 0; j < 4; j++) begin
      logic signed [63:0] p;
      p = $signed(a[32*j +: 32]) * $signed(b[32*j +: 32]);
      s += p[47:16];
    end
    return s;
  endfunction

  function automatic logic [127:0] bxform(logic [127:0] v);
    logic [127:0] r;
    for (int i = 0; i < 4; i++) r[32*i +: 32] = bdot(mrow[i], v);
    return r;
  endfunction

  // Output monitor: value, latency and order (R1 R3 R4 R6 R8)
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) begin
        chk(0, "R8 unexpected beat", out_data, '0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(out_data === e.d, e.req, out_data, e.d);
        chk(cyc == e.due, {e.req, " latency (R3/R6)"}, 128'(cyc), 128'(e.due));
      end
    end
  end

  // Caller is at a negedge; returns at the negedge after acceptance
  task automatic issue(logic op, logic [127:0] a, logic [127:0] b, string req);
    exp_t e;
    in_valid = 1; in_op = op; in_a = a; in_b = b;
    while (!in_ready) @(negedge clk);
    e.d   = op ? bxform(a) : {96'b0, bdot(a, b)};
    e.due = cyc + (op ? 6 : 3);
    e.req = req;
    q.push_back(e);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic load(logic [1:0] r, logic [127:0] d);
    mat_we = 1; mat_row = r; mat_data = d;
    @(negedge clk);
    mat_we = 0;
    mrow[r] = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) mrow[i] = '0;
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1, "R9 ready in reset", 128'(in_ready), 1);
    chk(out_valid === 1'b0, "R9 valid in reset", 128'(out_valid), 0);
    rst_n = 1;
    @(negedge clk);
    chk(in_ready === 1'b1, "R9 ready after reset", 128'(in_ready), 1);

    // R9: zero matrix after reset
    issue(1, 128'h00010000_00020000_00030000_00040000, '0, "R9 zero matrix");
    repeat (8) @(negedge clk);

    load(0, 128'h00000000_00000000_00000000_00010000);
    load(1, 128'h00000000_00000000_00020000_00000000);
    load(2, 128'h00008000_FFFF0000_00000000_00010000);
    load(3, 128'h00010000_00010000_00010000_00010000);

    // R1 R2: table of dot vectors, back-to-back
    for (int i = 0; i < NV; i++) begin
      chk(in_ready === 1'b1, "R2 ready for dot stream", 128'(in_ready), 1);
      issue(0, TA[i], TB[i], "R1 dot value");
    end
    repeat (6) @(negedge clk);

    // R4 R10: transform ignores in_b
    issue(1, 128'h00030000_FFFE0000_00018000_00010000,
          128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF, "R4 R10 transform");
    // R5: ready low three cycles, then high
    chk(in_ready === 1'b0, "R5 gap 1", 128'(in_ready), 0);
    @(negedge clk); chk(in_ready === 1'b0, "R5 gap 2", 128'(in_ready), 0);
    @(negedge clk); chk(in_ready === 1'b0, "R5 gap 3", 128'(in_ready), 0);
    @(negedge clk); chk(in_ready === 1'b1, "R5 ready again", 128'(in_ready), 1);
    repeat (8) @(negedge clk);

    // R7: writes while a transform is in flight do not reach it
    issue(1, 128'h00010000_00010000_00010000_00010000, '0, "R7 busy writes");
    load(1, 128'h11110000_22220000_33330000_44440000);
    load(3, 128'hFFFF0000_FFFF0000_FFFF0000_FFFF0000);
    repeat (8) @(negedge clk);

    // R7: write in the very cycle of issue does not reach it
    begin
      exp_t e;
      logic [127:0] v;
      v = 128'h00020000_00010000_00000000_00010000;
      in_valid = 1; in_op = 1; in_a = v; in_b = '0;
      mat_we = 1; mat_row = 2; mat_data = 128'h00050000_00050000_00050000_00050000;
      e.d = bxform(v); e.due = cyc + 6; e.req = "R7 same-cycle write";
      q.push_back(e);
      @(negedge clk);
      in_valid = 0; mat_we = 0;
      mrow[2] = 128'h00050000_00050000_00050000_00050000;
    end
    repeat (8) @(negedge clk);
    issue(1, 128'h00020000_00010000_00000000_00010000, '0, "R7 row write took effect");
    repeat (8) @(negedge clk);

    // R8: interleaved order
    issue(0, TA[0], TB[1], "R8 dot before transform");
    issue(1, TA[1], '0, "R8 transform");
    issue(0, TA[2], TB[3], "R8 dot after transform");
    issue(0, TA[3], TB[0], "R8 second dot after transform");
    repeat (10) @(negedge clk);
    chk(q.size() == 0, "R8 all results delivered", 128'(q.size()), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule